// File: doc/BRIEF.md
# Two-Channel Audio Serial Transmitter

This block takes 24-bit left and right audio samples as parallel words and sends them out on a single serial data line. The serial frame carries 128 bit clocks: 64 for the left slot and 64 for the right slot. Each word is sent most significant bit first in two's complement. Unused bit positions in a slot are driven low.

Two static mode pins choose the framing. One pin selects who owns the bit clock and the channel clock. As timing master, the block makes both clocks from a 256fs enable pulse. As timing slave, it synchronises clocks supplied from outside. The other pin selects the channel-clock polarity and the data alignment. In left-justified form, the channel clock is high for left and the MSB follows the channel-clock edge at once. In I2S form, the channel clock is low for left and the MSB comes one bit clock later.

The producer hands over a sample pair through a valid/ready handshake into a one-deep buffer. The pair is picked up at the start of the next left slot. If no pair is waiting at that point, the previous pair is sent again.

Top module: `aud_ser_tx`

## Requirements
- R1: `mode_i` bit 0 selects master (1) or slave (0) timing, and bit 1 selects I2S framing (1) or left-justified framing (0). The four codes are: 00 left-justified slave, 01 left-justified master, 10 I2S slave, 11 I2S master.
- R2: In master mode, `bclk_o` toggles once on every cycle where `tick_i` is high and holds otherwise. It is high after reset. In slave mode, `bclk_o` and `lrck_o` stay low.
- R3: In master mode, `lrck_o` toggles every 128 ticks, together with a falling edge of `bclk_o`. This gives 64 bit clocks per slot. The first slot after reset is a left slot. `lrck_o` is high for left in left-justified mode and low for left in I2S mode.
- R4: In slave mode, `bclk_i` and `lrck_i` are synchronised. A change of `lrck_i` seen at a falling edge of `bclk_i` starts a slot. The left slot is marked by `lrck_i` high (left-justified) or low (I2S).
- R5: Each slot carries its channel's 24-bit word MSB first. In left-justified mode, bit 23 is on the first bit clock of the slot. In I2S mode, bit 23 is on the second bit clock and the first bit clock carries 0.
- R6: Every bit position of a slot outside the 24 data bits is driven as 0.
- R7: `sdata_o` changes only together with a falling edge of the bit clock, so a receiver can sample it on the rising edge.
- R8: `ready_o` is high when the one-deep buffer is empty. A pair accepted with `valid_i` and `ready_o` both high closes `ready_o` until the next left-slot start. While `ready_o` is low, `valid_i` has no effect. The accepted pair is sent in both slots of the frame that follows.
- R9: If no pair is buffered when a left slot starts, the previously sent pair is repeated.
- R10: After reset, `sdata_o` is 0, `ready_o` is 1, and the sent pair is all zero until the first pair is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Static format select: {I2S, master} |
| tick_i | input | 1 | 256fs enable pulse, used in master mode |
| bclk_i | input | 1 | External bit clock, used in slave mode |
| lrck_i | input | 1 | External channel clock, used in slave mode |
| valid_i | input | 1 | Sample pair valid |
| ready_o | output | 1 | Buffer free, pair accepted when valid_i is also high |
| left_i | input | 24 | Left sample, two's complement |
| right_i | input | 24 | Right sample, two's complement |
| sdata_o | output | 1 | Serial data, MSB first |
| bclk_o | output | 1 | Generated bit clock (master mode) |
| lrck_o | output | 1 | Generated channel clock (master mode) |

## Verification
The bench decodes every slot in all four modes as a receiver would, sampling on each rising bit-clock edge, and compares all 64 bits of the slot. This catches the following errors:
- An off-by-one I2S delay would shift every word by one position.
- A swapped polarity would put the right word in the left slot.
- Leaking into the padding would set bits past the word.
- Taking a new pair mid-frame, instead of at the left-slot start, would split a pair across frames.
- Losing the hold register on a skipped frame would send zeros instead of a repeat.

The bench also tries to push a second pair while the buffer is full and confirms that the pair never reaches the line. It measures the bit-clock period, and it flags any data change that is not paired with a falling bit-clock edge.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

  typedef enum logic [1:0] {
    FMT_LJ_SLV  = 2'b00,
    FMT_LJ_MST  = 2'b01,
    FMT_I2S_SLV = 2'b10,
    FMT_I2S_MST = 2'b11
  } fmt_e;

  // One bit-clock falling edge worth of timing information
  typedef struct packed {
    logic fall;
    logic slot_start;
    logic left;
  } slot_ev_t;

endpackage

// File: rtl/aud_tx_mclk.sv
module aud_tx_mclk
  import aud_tx_pkg::*;
#(
  parameter int SLOT_BITS = 64
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  logic     i2s_i,
  input  logic     tick_i,
  output logic     bclk_o,
  output logic     lrck_o,
  output slot_ev_t ev_o
);
  localparam int CNT_W = $clog2(SLOT_BITS) + 2;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign cnt_d = cnt_q + 1'b1;

  // all ones at reset: the first tick falls bclk and opens a left slot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '1;
    else if (en_i && tick_i)  cnt_q <= cnt_d;
  end

  assign ev_o.fall       = en_i & tick_i & cnt_q[0];
  assign ev_o.slot_start = ev_o.fall & (cnt_d[CNT_W-2:0] == '0);
  assign ev_o.left       = ~cnt_d[CNT_W-1];

  assign bclk_o = en_i & cnt_q[0];
  assign lrck_o = en_i & (i2s_i ? cnt_q[CNT_W-1] : ~cnt_q[CNT_W-1]);

  assert_bclk_toggle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i) |=> (bclk_o != $past(bclk_o)));

  assert_bclk_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> $stable(bclk_o));

  assert_lrck_on_fall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(lrck_o) || $fell(lrck_o)) |-> $fell(bclk_o));

endmodule

// File: rtl/aud_tx_ssync.sv
module aud_tx_ssync
  import aud_tx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  logic     i2s_i,
  input  logic     bclk_i,
  input  logic     lrck_i,
  output slot_ev_t ev_o
);
  logic [SYNC_STAGES:0]   bclk_q;
  logic [SYNC_STAGES-1:0] lrck_q;
  logic                   lr_last_q, armed_q;
  logic                   fall, lr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q <= '0;
      lrck_q <= '0;
    end else begin
      bclk_q <= {bclk_q[SYNC_STAGES-1:0], bclk_i};
      lrck_q <= {lrck_q[SYNC_STAGES-2:0], lrck_i};
    end
  end

  assign fall = en_i & bclk_q[SYNC_STAGES] & ~bclk_q[SYNC_STAGES-1];
  assign lr   = lrck_q[SYNC_STAGES-1];

  // first fall only records the channel level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lr_last_q <= 1'b0;
      armed_q   <= 1'b0;
    end else if (fall) begin
      lr_last_q <= lr;
      armed_q   <= 1'b1;
    end
  end

  assign ev_o.fall       = fall;
  assign ev_o.slot_start = fall & armed_q & (lr != lr_last_q);
  assign ev_o.left       = i2s_i ? ~lr : lr;

  assert_slave_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !ev_o.fall);

endmodule

// File: rtl/aud_tx_ser.sv
module aud_tx_ser
  import aud_tx_pkg::*;
#(
  parameter int SAMPLE_W  = 24,
  parameter int SLOT_BITS = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  slot_ev_t            ev_i,
  input  logic                i2s_i,
  input  logic                valid_i,
  output logic                ready_o,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                sdata_o
);
  localparam int POS_W = $clog2(SLOT_BITS);
  localparam logic [POS_W-1:0] POS_MAX  = POS_W'(SLOT_BITS - 1);
  localparam logic [POS_W:0]   DATA_END = (POS_W+1)'(SAMPLE_W);

  logic [SAMPLE_W-1:0] buf_l_q, buf_r_q, hold_l_q, hold_r_q;
  logic [SAMPLE_W-1:0] src_l, src_r, word, word_sh;
  logic                full_q, take, accept;
  logic [POS_W-1:0]    pos_q, pos_d;
  logic [POS_W:0]      dpos;
  logic                cur_left_q, chan_left, armed_q, armed_d, in_rng, bit_d, sdata_q;

  assign take   = ev_i.fall & ev_i.slot_start & ev_i.left;
  assign accept = valid_i & ~full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q  <= 1'b0;
      buf_l_q <= '0;
      buf_r_q <= '0;
    end else if (take && full_q) begin
      full_q <= 1'b0;
    end else if (accept) begin
      full_q  <= 1'b1;
      buf_l_q <= left_i;
      buf_r_q <= right_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_l_q <= '0;
      hold_r_q <= '0;
    end else if (take && full_q) begin
      hold_l_q <= buf_l_q;
      hold_r_q <= buf_r_q;
    end
  end

  assign src_l = (take && full_q) ? buf_l_q : hold_l_q;
  assign src_r = (take && full_q) ? buf_r_q : hold_r_q;

  always_comb begin
    if (ev_i.slot_start)       pos_d = '0;
    else if (pos_q == POS_MAX) pos_d = pos_q;
    else                       pos_d = pos_q + 1'b1;
  end

  assign chan_left = ev_i.slot_start ? ev_i.left : cur_left_q;
  assign armed_d   = armed_q | ev_i.slot_start;
  assign dpos      = {1'b0, pos_d} - {{POS_W{1'b0}}, i2s_i};
  assign in_rng    = (!i2s_i || pos_d != '0) && (dpos < DATA_END);
  assign word      = chan_left ? src_l : src_r;
  assign word_sh   = word << dpos;
  assign bit_d     = armed_d & in_rng & word_sh[SAMPLE_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q      <= POS_MAX;
      cur_left_q <= 1'b0;
      armed_q    <= 1'b0;
      sdata_q    <= 1'b0;
    end else if (ev_i.fall) begin
      pos_q      <= pos_d;
      cur_left_q <= chan_left;
      armed_q    <= armed_d;
      sdata_q    <= bit_d;
    end
  end

  assign ready_o = ~full_q;
  assign sdata_o = sdata_q;

  assert_sdata_on_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ev_i.fall |=> $stable(sdata_o));

  assert_pad_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i.fall && !ev_i.slot_start && ({1'b0, pos_q} >= DATA_END)) |=> !sdata_o);

  assert_accept_closes_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> !ready_o);

  assert_take_reopens_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !ready_o) |=> ready_o);

endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx
  import aud_tx_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int SLOT_BITS   = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          mode_i,
  input  logic                tick_i,
  input  logic                bclk_i,
  input  logic                lrck_i,
  input  logic                valid_i,
  output logic                ready_o,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                sdata_o,
  output logic                bclk_o,
  output logic                lrck_o
);
  fmt_e     fmt;
  logic     is_master, is_i2s;
  slot_ev_t m_ev, s_ev, ev;

  assign fmt       = fmt_e'(mode_i);
  assign is_master = (fmt == FMT_LJ_MST) || (fmt == FMT_I2S_MST);
  assign is_i2s    = (fmt == FMT_I2S_SLV) || (fmt == FMT_I2S_MST);

  aud_tx_mclk #(.SLOT_BITS(SLOT_BITS)) u_mclk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (is_master),
    .i2s_i  (is_i2s),
    .tick_i (tick_i),
    .bclk_o (bclk_o),
    .lrck_o (lrck_o),
    .ev_o   (m_ev)
  );

  aud_tx_ssync #(.SYNC_STAGES(SYNC_STAGES)) u_ssync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (!is_master),
    .i2s_i  (is_i2s),
    .bclk_i (bclk_i),
    .lrck_i (lrck_i),
    .ev_o   (s_ev)
  );

  assign ev = is_master ? m_ev : s_ev;

  aud_tx_ser #(.SAMPLE_W(SAMPLE_W), .SLOT_BITS(SLOT_BITS)) u_ser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ev_i    (ev),
    .i2s_i   (is_i2s),
    .valid_i (valid_i),
    .ready_o (ready_o),
    .left_i  (left_i),
    .right_i (right_i),
    .sdata_o (sdata_o)
  );

  assert_slave_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_master |-> (!bclk_o && !lrck_o));

endmodule

// File: tb/sim_aud_ser_tx.sv
`timescale 1ns/1ps
module sim_aud_ser_tx;
  localparam int SW = 24;
  localparam int SB = 64;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [1:0]    mode_i = 2'b00;
  logic          tick_i = 1'b0;
  logic          bclk_i = 1'b1;
  logic          lrck_i = 1'b0;
  logic          valid_i = 1'b0;
  logic          ready_o;
  logic [SW-1:0] left_i = '0;
  logic [SW-1:0] right_i = '0;
  logic          sdata_o, bclk_o, lrck_o;

  int checks = 0;
  int errors = 0;
  logic tick_en = 1'b0;

  // receiver model state
  logic          rx_prev_lr, rx_in_slot, rx_left, rx_first;
  int            rx_cnt, left_cnt;
  logic [63:0]   rx_bits;
  logic [SW-1:0] cur_l, cur_r, pend_l, pend_r;
  logic          pend_v;

  aud_ser_tx u0 (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i), .tick_i(tick_i),
    .bclk_i(bclk_i), .lrck_i(lrck_i), .valid_i(valid_i), .ready_o(ready_o),
    .left_i(left_i), .right_i(right_i), .sdata_o(sdata_o),
    .bclk_o(bclk_o), .lrck_o(lrck_o)
  );

  always #4 clk = ~clk;

  always @(negedge clk) tick_i <= tick_en ? ~tick_i : 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_slot(input logic [SW-1:0] w, input logic i2s);
    logic [63:0] e = '0;
    for (int k = 0; k < SW; k++) e[k + (i2s ? 1 : 0)] = w[SW-1-k];
    return e;
  endfunction

  function automatic logic lvl(input logic left, input logic i2s);
    return i2s ? !left : left;
  endfunction

  task automatic finish_slot();
    logic [SW-1:0] w;
    w = rx_left ? cur_l : cur_r;
    chk(rx_cnt == SB, mode_i[0] ? "R3" : "R4", "slot length", 64'(rx_cnt), 64'(SB));
    chk(rx_bits == exp_slot(w, mode_i[1]),
        mode_i[0] ? "R3 R5 R6 R9" : "R4 R5 R6 R9",
        rx_left ? "left slot bits" : "right slot bits", rx_bits, exp_slot(w, mode_i[1]));
  endtask

  task automatic rx_sample(input logic lr, input logic sd);
    if (lr != rx_prev_lr) begin
      if (rx_in_slot) finish_slot();
      rx_left = lvl(lr, mode_i[1]);
      if (rx_first) begin
        chk(rx_left, "R3", "first slot is left", 64'(rx_left), 64'd1);
        rx_first = 1'b0;
      end
      if (rx_left) begin
        if (pend_v) begin
          cur_l = pend_l;
          cur_r = pend_r;
          pend_v = 1'b0;
        end
        left_cnt++;
      end
      rx_in_slot = 1'b1;
      rx_cnt = 0;
      rx_bits = '0;
    end
    rx_prev_lr = lr;
    if (rx_in_slot) begin
      if (rx_cnt < SB) rx_bits[rx_cnt] = sd;
      rx_cnt++;
    end
  endtask

  task automatic do_reset(input logic [1:0] m);
    rst_ni = 1'b0;
    mode_i = m;
    tick_en = 1'b0;
    valid_i = 1'b0;
    bclk_i = 1'b1;
    lrck_i = lvl(1'b0, m[1]);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    rx_in_slot = 1'b0;
    rx_first = 1'b1;
    rx_cnt = 0;
    rx_bits = '0;
    left_cnt = 0;
    cur_l = '0;
    cur_r = '0;
    pend_v = 1'b0;
    rx_prev_lr = m[0] ? lrck_o : lrck_i;
    chk(sdata_o == 1'b0, "R10", "reset sdata", 64'(sdata_o), 64'd0);
    chk(ready_o == 1'b1, "R10", "reset ready", 64'(ready_o), 64'd1);
    chk(bclk_o == m[0], "R2", "reset bclk", 64'(bclk_o), 64'(m[0]));
    chk(lrck_o == (m[0] & m[1]), "R3", "reset lrck (right level)", 64'(lrck_o), 64'(m[0] & m[1]));
  endtask

  task automatic feed(input int nf, input int gap);
    logic [SW-1:0] l, r;
    for (int f = 0; f < nf; f++) begin
      wait (left_cnt > f);
      repeat (gap) @(negedge clk);
      if (f >= 3 && ($urandom % 3) == 0) continue;  // R9: skip, pair repeats
      case (f)
        1:       begin l = 24'h800000; r = 24'h000001; end
        2:       begin l = 24'hFFFFFF; r = 24'h7FFFFF; end
        default: begin l = 24'($urandom); r = 24'($urandom); end
      endcase
      chk(ready_o == 1'b1, "R8", "ready open before push", 64'(ready_o), 64'd1);
      valid_i = 1'b1;
      left_i = l;
      right_i = r;
      @(negedge clk);
      pend_l = l;
      pend_r = r;
      pend_v = 1'b1;
      chk(ready_o == 1'b0, "R8", "ready closed after accept", 64'(ready_o), 64'd0);
      // R8: a second push while full must be dropped
      left_i = ~l;
      right_i = ~r;
      repeat (4) @(negedge clk);
      chk(ready_o == 1'b0, "R8", "ready stays closed while full", 64'(ready_o), 64'd0);
      valid_i = 1'b0;
    end
  endtask

  task automatic run_master(input int nf);
    logic pb, psd;
    int since, r2_bad, r2_seen, r7_bad;
    pb = bclk_o; psd = sdata_o; since = -1; r2_bad = 0; r2_seen = 0; r7_bad = 0;
    tick_en = 1'b1;
    fork
      feed(nf, 40);
      while (left_cnt < nf + 2) begin
        @(negedge clk);
        if (since >= 0) since++;
        if (bclk_o && !pb) begin
          if (since > 0 && since != 4) r2_bad++;
          r2_seen++;
          since = 0;
          rx_sample(lrck_o, sdata_o);
        end
        if (sdata_o != psd && !(pb && !bclk_o)) r7_bad++;
        pb = bclk_o;
        psd = sdata_o;
      end
    join
    chk(r2_bad == 0 && r2_seen > 0, "R2", "bclk period 2 ticks", 64'(r2_bad), 64'd0);
    chk(r7_bad == 0, "R7", "data moves only at bclk fall", 64'(r7_bad), 64'd0);
  endtask

  task automatic sbit(input logic lr);
    @(negedge clk);
    bclk_i = 1'b0;
    lrck_i = lr;
    repeat (8) @(negedge clk);
    rx_sample(lrck_i, sdata_o);
    bclk_i = 1'b1;
    repeat (7) @(negedge clk);
  endtask

  task automatic run_slave(input int nf);
    logic i2s;
    i2s = mode_i[1];
    fork
      feed(nf, 60);
      begin
        for (int b = 0; b < 4; b++) sbit(lvl(1'b0, i2s));
        for (int fr = 0; fr < nf + 2; fr++) begin
          for (int b = 0; b < SB; b++) sbit(lvl(1'b1, i2s));
          for (int b = 0; b < SB; b++) sbit(lvl(1'b0, i2s));
        end
        sbit(lvl(1'b1, i2s));
      end
    join
    chk(bclk_o == 1'b0 && lrck_o == 1'b0, "R1 R2", "slave mode clocks quiet",
        64'({bclk_o, lrck_o}), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1a2b3c4d));
    do_reset(2'b01); run_master(5);
    do_reset(2'b11); run_master(5);
    do_reset(2'b00); run_slave(4);
    do_reset(2'b10); run_slave(4);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule